// File: doc/BRIEF.md
# Dual-Domain Reset Release Controller

This block produces two active-low resets for logic that shares one system clock. The first reset drives the processor, the interconnect and the user logic. The second reset drives only the debug logic. Each reset asserts as soon as one of its assert conditions appears, with no clock edge needed. It releases cleanly on a clock edge after passing through its own chain of synchronizing flops.

Three inputs feed the block: an external active-low reset, a level that reports that the clock generator has locked, and a request from the debug logic to reset everything except the debug logic. The external reset and a missing lock hold both domains in reset. The debug request holds only the system domain in reset, so a debugger can restart the core without losing its own state. The block has no data path, so there is no valid/ready interface; every pin is a plain level.

Top module: `rstc_top`

## Requirements
- R1: While `ext_rst_ni` is low, both `sys_rst_no` and `dbg_rst_no` are low, and they go low without waiting for a clock edge.
- R2: While `locked_i` is low, both outputs are low, and they go low without waiting for a clock edge.
- R3: While `ndm_req_i` is high (1 = request), `sys_rst_no` is low. The request has no effect on `dbg_rst_no`.
- R4: While `ext_rst_ni` and `locked_i` stay high, `dbg_rst_no` does not change, whatever `ndm_req_i` does.
- R5: A reset output goes high on exactly the SYNC_DEPTH-th rising clock edge after the last of its assert conditions is removed, and not earlier. The default SYNC_DEPTH is 2.
- R6: If an assert condition is present from time zero, both outputs read low before the first clock edge.
- R7: `ndm_req_i` acts as a level. `sys_rst_no` stays low for as long as the request is held, then releases SYNC_DEPTH edges after the request falls.
- R8: When lock is lost during operation, both outputs assert at once. They release only SYNC_DEPTH edges after lock returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that drives both synchronizer chains |
| ext_rst_ni | input | 1 | External reset, active low |
| locked_i | input | 1 | Clock generator locked, active high |
| ndm_req_i | input | 1 | Debug request to reset the non-debug logic, active high level |
| sys_rst_no | output | 1 | Reset for the system domain, active low |
| dbg_rst_no | output | 1 | Reset for the debug domain, active low |

## Verification
A fault in a synchronizer chain shows up as a release that is early or late by at least one clock. The per-cycle reference catches this on the first falling edge after the wrong edge. A fault in the condition logic shows up differently: a debug reset that drops on a debug request, or a system reset that stays high while the request is present. The checks made straight after each input change find such a fault before the next clock edge. A missing asynchronous path shows the same way, because an output stays high in the half cycle after an input asserts, where the bench samples it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned DOM_SYS = 0;
  localparam int unsigned DOM_DBG = 1;
  localparam int unsigned NUM_DOM = 2;
  typedef logic [NUM_DOM-1:0] dom_vec_t;
endpackage

// File: rtl/rstc_cond.sv
module rstc_cond
  import rstc_pkg::*;
(
  input  logic     ext_rst_ni,
  input  logic     locked_i,
  input  logic     ndm_req_i,
  output dom_vec_t clear_no
);
  logic base_ok;
  assign base_ok = ext_rst_ni & locked_i;

  always_comb begin
    clear_no          = '0;
    clear_no[DOM_DBG] = base_ok;
    clear_no[DOM_SYS] = base_ok & ~ndm_req_i;
  end
endmodule

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic clear_ni,
  output logic rst_no
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] acap_q;

  always_ff @(posedge clk_i or negedge clear_ni) begin
    if (!clear_ni) acap_q <= '0;
    else           acap_q <= {acap_q[DEPTH-2:0], 1'b1};
  end

  // The gate keeps the output low from time zero whenever clear is present.
  assign rst_no = acap_q[DEPTH-1] & clear_ni;

  // Release watchdog: edges seen since clear was removed, saturating.
  logic [CW-1:0] rel_cnt_q;
  always_ff @(posedge clk_i or negedge clear_ni) begin
    if (!clear_ni)                   rel_cnt_q <= '0;
    else if (rel_cnt_q != CW'(DEPTH)) rel_cnt_q <= rel_cnt_q + CW'(1);
  end

  // R5: release happens on exactly the DEPTH-th edge
  assert_release_latency_R5: assert property (@(posedge clk_i) disable iff (!clear_ni)
    $rose(rst_no) |-> (rel_cnt_q == CW'(DEPTH)));
  assert_release_not_late_R5: assert property (@(posedge clk_i) disable iff (!clear_ni)
    (rel_cnt_q == CW'(DEPTH)) |-> rst_no);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk_i,
  input  logic ext_rst_ni,
  input  logic locked_i,
  input  logic ndm_req_i,
  output logic sys_rst_no,
  output logic dbg_rst_no
);
  dom_vec_t clear_n;
  dom_vec_t rst_n;

  rstc_cond u_cond (
    .ext_rst_ni (ext_rst_ni),
    .locked_i   (locked_i),
    .ndm_req_i  (ndm_req_i),
    .clear_no   (clear_n)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rstc_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
      .clk_i    (clk_i),
      .clear_ni (clear_n[d]),
      .rst_no   (rst_n[d])
    );
  end

  assign sys_rst_no = rst_n[DOM_SYS];
  assign dbg_rst_no = rst_n[DOM_DBG];

  assert_ext_holds_both_R1: assert property (@(posedge clk_i) disable iff (!locked_i)
    !ext_rst_ni |-> (!sys_rst_no && !dbg_rst_no));
  assert_lock_holds_both_R2: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
    !locked_i |-> (!sys_rst_no && !dbg_rst_no));
  assert_req_holds_sys_R3: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
    ndm_req_i |-> !sys_rst_no);
  assert_dbg_no_drop_R4: assert property (@(posedge clk_i) disable iff (!(ext_rst_ni && locked_i))
    $past(dbg_rst_no) |-> dbg_rst_no);
endmodule

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
  localparam int unsigned D = 2;
  localparam real CLK_MHZ = 125.0;
  localparam real HALF_NS = 500.0 / CLK_MHZ;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic locked = 1'b0;
  logic ndm_req = 1'b0;
  logic sys_rst_n, dbg_rst_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(HALF_NS * 1ns) clk = ~clk;

  rstc_top #(.SYNC_DEPTH(D)) u0 (
    .clk_i(clk), .ext_rst_ni(ext_rst_n), .locked_i(locked), .ndm_req_i(ndm_req),
    .sys_rst_no(sys_rst_n), .dbg_rst_no(dbg_rst_n)
  );

  // Behavioural reference: edges since each domain's conditions cleared.
  int cnt_sys = 0;
  int cnt_dbg = 0;
  function automatic bit ok_dbg();
    return ext_rst_n && locked;
  endfunction
  function automatic bit ok_sys();
    return ext_rst_n && locked && !ndm_req;
  endfunction
  always @(posedge clk) begin
    cnt_sys <= !ok_sys() ? 0 : (cnt_sys < D ? cnt_sys + 1 : cnt_sys);
    cnt_dbg <= !ok_dbg() ? 0 : (cnt_dbg < D ? cnt_dbg + 1 : cnt_dbg);
  end
  function automatic bit exp_sys();
    return ok_sys() && (cnt_sys >= D);
  endfunction
  function automatic bit exp_dbg();
    return ok_dbg() && (cnt_dbg >= D);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic cmp_model(string req);
    chk({req, " sys"}, sys_rst_n, exp_sys());
    chk({req, " dbg"}, dbg_rst_n, exp_dbg());
  endtask

  // Per-cycle comparison on every falling edge.
  bit run_cmp = 1'b0;
  always @(negedge clk) if (run_cmp && !done) cmp_model("model");

  // Drive point: 2 ns after a rising edge, away from both edges.
  task automatic to_drive();
    @(posedge clk);
    #2ns;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2ns;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(HALF_NS * 2.0 * 200000.0 * 1ns);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  bit dbg_dropped;
  always @(negedge dbg_rst_n) if (ndm_req && ext_rst_n && locked) dbg_dropped = 1'b1;

  initial begin
    #1ns;
    chk("R6 sys at power-up", sys_rst_n, 1'b0);
    chk("R6 dbg at power-up", dbg_rst_n, 1'b0);
    run_cmp = 1'b1;
    cycles(3);
    locked = 1'b1;
    cycles(2);
    chk("R1 sys held by ext", sys_rst_n, 1'b0);
    chk("R1 dbg held by ext", dbg_rst_n, 1'b0);

    // R5: exact release latency
    ext_rst_n = 1'b0; to_drive();
    ext_rst_n = 1'b1;
    for (int i = 1; i < D; i++) @(posedge clk);
    #1ns;
    chk("R5 sys before edge D", sys_rst_n, 1'b0);
    chk("R5 dbg before edge D", dbg_rst_n, 1'b0);
    @(posedge clk); #1ns;
    chk("R5 sys at edge D", sys_rst_n, 1'b1);
    chk("R5 dbg at edge D", dbg_rst_n, 1'b1);
    cycles(2);

    // R3 / R7: held request
    ndm_req = 1'b1; #1ns;
    chk("R3 sys async on request", sys_rst_n, 1'b0);
    chk("R3 dbg unaffected", dbg_rst_n, 1'b1);
    cycles(6);
    chk("R7 sys still held", sys_rst_n, 1'b0);
    ndm_req = 1'b0;
    for (int i = 1; i < D; i++) @(posedge clk);
    #1ns;
    chk("R7 sys before edge D", sys_rst_n, 1'b0);
    @(posedge clk); #1ns;
    chk("R7 sys released at edge D", sys_rst_n, 1'b1);
    cycles(2);

    // R4: pulse train of requests, debug reset must not move
    dbg_dropped = 1'b0;
    for (int p = 0; p < 8; p++) begin
      ndm_req = 1'b1;
      cycles(1 + (p % 3));
      ndm_req = 1'b0;
      cycles(p % 4);
    end
    chk("R4 dbg never dropped during pulses", dbg_dropped, 1'b0);
    chk("R4 dbg high after pulses", dbg_rst_n, 1'b1);
    cycles(D + 1);

    // R8 / R2: lock loss while running
    locked = 1'b0; #1ns;
    chk("R2 sys async on lock loss", sys_rst_n, 1'b0);
    chk("R2 dbg async on lock loss", dbg_rst_n, 1'b0);
    cycles(4);
    locked = 1'b1;
    for (int i = 1; i < D; i++) @(posedge clk);
    #1ns;
    chk("R8 dbg still low before edge D", dbg_rst_n, 1'b0);
    @(posedge clk); #1ns;
    chk("R8 sys re-released", sys_rst_n, 1'b1);
    chk("R8 dbg re-released", dbg_rst_n, 1'b1);
    cycles(2);

    // R1: external reset mid-run, no clock edge needed
    ext_rst_n = 1'b0; #1ns;
    chk("R1 sys async on ext", sys_rst_n, 1'b0);
    chk("R1 dbg async on ext", dbg_rst_n, 1'b0);
    cycles(3);

    // Request overlapping lock loss and ext release
    ndm_req = 1'b1; ext_rst_n = 1'b1; locked = 1'b0;
    cycles(3);
    locked = 1'b1;
    cycles(D + 2);
    chk("R3 dbg releases under request", dbg_rst_n, 1'b1);
    chk("R7 sys held under request", sys_rst_n, 1'b0);
    ndm_req = 1'b0;
    cycles(D + 2);
    chk("R7 sys final release", sys_rst_n, 1'b1);

    run_cmp = 1'b0;
    finish_run();
  end
endmodule